// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Controller

This block arbitrates ten vectored interrupt request lines for a small processor core. Software gives every vector a priority level, and the controller presents one request at a time to the core. The lowest two vectors may run at the top level, which outranks everything. The other eight vectors may run only at the middle or bottom level. The controller drives a request flag and the entry address of the vector that wins. Ten entry points are spaced eight bytes apart, starting at 03h.

When the core accepts an interrupt it pulses the acknowledge strobe, and the controller pushes the level of that vector onto a short in-service stack. While a handler runs, only requests at a strictly higher level can reach the core. Requests at the same or a lower level stay pending and are offered once the handler's return strobe pops the stack. There are three levels, so at most three handlers can be nested. The request lines are level-sensitive and are cleared upstream, where several sources may also be merged onto one line.

Top module: `prio_vec_ctrl`

## Requirements
- R1: After synchronous reset the in-service stack is empty, so with no request pending `irq_o` is 0 and `vec_addr_o` is 0, and any single pending request is offered at once.
- R2: Request line k (bit k of `req_i`, k = 0..9) has entry address 3 + 8*k (03h up to 4Bh). `vec_addr_o` shows the winner's address while `irq_o` is 1 and reads 0 while `irq_o` is 0.
- R3: The level of vector k is the 2-bit field `lvl_i[2k+1:2k]`. Code 00 means low and 01 means high. Codes 10 and 11 mean highest on vectors 0 and 1, but only high on vectors 2 to 9.
- R4: Among pending requests the highest level wins: highest above high above low.
- R5: When several pending requests share the winning level, the lowest-numbered vector (lowest address) wins.
- R6: `irq_o` is 1 only when the winning request's level is strictly above the level at the top of the in-service stack. An empty stack ranks below low. Requests at the same or a lower level stay pending.
- R7: An acknowledge while `irq_o` is 1 pushes the winner's level, so in the next cycle the same request no longer raises `irq_o`.
- R8: A return strobe pops the most recent level. A return while the stack is empty has no effect.
- R9: An acknowledge while `irq_o` is 0 has no effect on the stack.
- R10: When acknowledge (with `irq_o` at 1) and return fall in the same cycle, the pop is applied first and the push second. The depth stays the same and the new top is the acknowledged level.
- R11: Handlers nest up to three deep, and the stacked levels strictly increase from bottom to top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 10 | Pending request per vector, level-sensitive |
| lvl_i | input | 20 | 2-bit level code per vector |
| ack_i | input | 1 | Core accepts the offered interrupt |
| ret_i | input | 1 | Core returns from the current handler |
| irq_o | output | 1 | Interrupt request to the core |
| vec_addr_o | output | 8 | Entry address of the offered vector |

## Verification
Acknowledge and return can land in the same cycle, and so can an acknowledge and a change in the request pattern. Directed sequences load a low handler, raise a higher request and then pulse both strobes together. A walk of mixed patterns also fires both strobes in pseudo-random pairs. A level-based reference stack in the bench predicts the resulting depth and top level. That prediction is judged from which requests can reach `irq_o` afterwards and which address is then offered.

// File: rtl/pvc_pkg.sv
package pvc_pkg;

    localparam int NUM_VEC    = 10;
    localparam int NUM_XCAP   = 2;
    localparam int ADDR_W     = 8;
    localparam int VEC_BASE   = 3;
    localparam int VEC_STEP   = 8;
    localparam int NEST_DEPTH = 3;
    localparam int IDX_W      = $clog2(NUM_VEC);

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_LOW  = 2'd1,
        RK_HIGH = 2'd2,
        RK_TOP  = 2'd3
    } rank_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        rank_e            rank;
    } pick_t;

    // Level code to internal rank; the top level only where the vector may use it
    function automatic rank_e decode_rank(input logic [1:0] code, input logic top_ok);
        rank_e r;
        case (code)
            2'b00:   r = RK_LOW;
            2'b01:   r = RK_HIGH;
            default: r = top_ok ? RK_TOP : RK_HIGH;
        endcase
        return r;
    endfunction

    function automatic logic [ADDR_W-1:0] entry_addr(input logic [IDX_W-1:0] idx);
        return ADDR_W'(VEC_BASE + VEC_STEP * int'(idx));
    endfunction

endpackage

// File: rtl/pvc_level_map.sv
module pvc_level_map
    import pvc_pkg::*;
#(
    parameter int N    = NUM_VEC,
    parameter int XCAP = NUM_XCAP
) (
    input  logic [N-1:0]   req_i,
    input  logic [2*N-1:0] lvl_i,
    output logic [2*N-1:0] rank_o
);

    for (genvar g = 0; g < N; g++) begin : g_vec
        localparam logic TOP_OK = (g < XCAP);
        rank_e r;
        always_comb begin
            r = RK_NONE;
            if (req_i[g]) r = decode_rank(lvl_i[2*g +: 2], TOP_OK);
        end
        assign rank_o[2*g +: 2] = r;
    end

endmodule

// File: rtl/pvc_arbiter.sv
module pvc_arbiter
    import pvc_pkg::*;
#(
    parameter int N = NUM_VEC
) (
    input  logic [2*N-1:0] rank_i,
    input  logic [1:0]     floor_i,
    output pick_t          pick_o
);

    always_comb begin
        pick_o.valid = 1'b0;
        pick_o.idx   = '0;
        pick_o.rank  = RK_NONE;
        // ascending scan, strict compare: ties keep the lowest index
        for (int i = 0; i < N; i++) begin
            if (rank_i[2*i +: 2] > pick_o.rank) begin
                pick_o.rank = rank_e'(rank_i[2*i +: 2]);
                pick_o.idx  = IDX_W'(i);
            end
        end
        pick_o.valid = (pick_o.rank > floor_i);
    end

endmodule

// File: rtl/pvc_nest_stack.sv
module pvc_nest_stack
    import pvc_pkg::*;
#(
    parameter int DEPTH = NEST_DEPTH,
    localparam int DW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [1:0]    rank_i,
    output logic [1:0]    top_o,
    output logic [DW-1:0] depth_o
);

    logic [1:0]    ent [DEPTH];
    logic [DW-1:0] depth_q;
    logic          eff_pop;
    logic [DW-1:0] wr_slot;

    assign eff_pop = pop_i && (depth_q != '0);
    assign wr_slot = eff_pop ? depth_q - 1'b1 : depth_q;
    assign depth_o = depth_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q <= '0;
            for (int k = 0; k < DEPTH; k++) ent[k] <= RK_NONE;
        end else begin
            if (push_i) begin
                for (int k = 0; k < DEPTH; k++) begin
                    if (wr_slot == DW'(k)) ent[k] <= rank_i;
                end
            end
            if (push_i && !eff_pop)      depth_q <= depth_q + 1'b1;
            else if (!push_i && eff_pop) depth_q <= depth_q - 1'b1;
        end
    end

    always_comb begin
        top_o = RK_NONE;
        for (int k = 0; k < DEPTH; k++) begin
            if (depth_q == DW'(k + 1)) top_o = ent[k];
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (push_i && !eff_pop) |-> (depth_q < DW'(DEPTH))); // R11

    AST_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i && depth_q == '0) |=> (depth_q == '0)); // R8

    for (genvar k = 1; k < DEPTH; k++) begin : g_order
        AST_NEST_ORDER: assert property (@(posedge clk) disable iff (rst)
            (depth_q > DW'(k)) |-> (ent[k] > ent[k-1])); // R11
    end

endmodule

// File: rtl/prio_vec_ctrl.sv
module prio_vec_ctrl
    import pvc_pkg::*;
#(
    parameter int NVEC   = NUM_VEC,
    parameter int XCAP   = NUM_XCAP,
    parameter int NEST   = NEST_DEPTH,
    parameter int AW     = ADDR_W,
    localparam int DW    = $clog2(NEST + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NVEC-1:0]   req_i,
    input  logic [2*NVEC-1:0] lvl_i,
    input  logic              ack_i,
    input  logic              ret_i,
    output logic              irq_o,
    output logic [AW-1:0]     vec_addr_o
);

    logic [2*NVEC-1:0] rank_vec;
    logic [1:0]        cur_rank;
    logic [DW-1:0]     depth;
    pick_t             pick;

    pvc_level_map #(.N(NVEC), .XCAP(XCAP)) u_map (
        .req_i  (req_i),
        .lvl_i  (lvl_i),
        .rank_o (rank_vec)
    );

    pvc_arbiter #(.N(NVEC)) u_arb (
        .rank_i  (rank_vec),
        .floor_i (cur_rank),
        .pick_o  (pick)
    );

    pvc_nest_stack #(.DEPTH(NEST)) u_stk (
        .clk     (clk),
        .rst     (rst),
        .push_i  (ack_i && pick.valid),
        .pop_i   (ret_i),
        .rank_i  (pick.rank),
        .top_o   (cur_rank),
        .depth_o (depth)
    );

    assign irq_o      = pick.valid;
    assign vec_addr_o = pick.valid ? AW'(entry_addr(pick.idx)) : '0;

    AST_SEL_REQ: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> req_i[pick.idx]); // R6

    AST_SEL_ABOVE: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (pick.rank > cur_rank)); // R6

    AST_XCAP: assert property (@(posedge clk) disable iff (rst)
        (irq_o && pick.idx >= IDX_W'(XCAP)) |-> (pick.rank != RK_TOP)); // R3

    AST_ACK_IDLE: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !irq_o && !ret_i) |=> (depth == $past(depth))); // R9

    AST_ACK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (ack_i && irq_o && !ret_i) |=> (!irq_o || pick.rank > $past(pick.rank))); // R7

    AST_SWAP: assert property (@(posedge clk) disable iff (rst)
        (ack_i && irq_o && ret_i && depth != '0) |=> (depth == $past(depth))); // R10

endmodule

// File: tb/tb_prio_vec_ctrl.sv
module tb_prio_vec_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NV-1:0] req = '0;
    logic [2*NV-1:0] lvl = '0;
    logic          ack = 1'b0;
    logic          ret = 1'b0;
    logic          irq;
    logic [7:0]    addr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int mstk [3];
    int mdepth = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_vec_ctrl dut (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req),
        .lvl_i      (lvl),
        .ack_i      (ack),
        .ret_i      (ret),
        .irq_o      (irq),
        .vec_addr_o (addr)
    );

    function automatic int exp_rank(int v);
        logic [1:0] c = lvl[2*v +: 2];
        if (c == 2'b00) return 1;
        if (c == 2'b01) return 2;
        return (v < 2) ? 3 : 2;
    endfunction

    function automatic int mtop();
        return (mdepth == 0) ? 0 : mstk[mdepth-1];
    endfunction

    task automatic exp_pick(output bit e_irq, output int e_idx, output int e_rank);
        e_rank = 0;
        e_idx = 0;
        for (int v = 0; v < NV; v++) begin
            if (req[v] && exp_rank(v) > e_rank) begin
                e_rank = exp_rank(v);
                e_idx = v;
            end
        end
        e_irq = (e_rank > mtop());
    endtask

    task automatic check(string tag);
        bit e_irq; int e_idx; int e_rank; int e_addr;
        #1;
        exp_pick(e_irq, e_idx, e_rank);
        e_addr = e_irq ? 3 + 8 * e_idx : 0;
        n_chk++;
        if (irq !== e_irq || addr !== 8'(e_addr)) begin
            n_fail++;
            $display("FAIL %s: irq=%0b addr=%0h expected irq=%0b addr=%0h", tag, irq, addr, e_irq, e_addr);
        end
    endtask

    task automatic set_in(logic [NV-1:0] r, logic [2*NV-1:0] l);
        @(negedge clk);
        req = r;
        lvl = l;
    endtask

    task automatic strobe(bit a, bit r);
        bit e_irq; int e_idx; int e_rank;
        @(negedge clk);
        ack = a;
        ret = r;
        #1;
        exp_pick(e_irq, e_idx, e_rank);
        @(posedge clk);
        if (r && mdepth > 0) mdepth--;
        if (a && e_irq) begin
            mstk[mdepth] = e_rank;
            mdepth++;
        end
        @(negedge clk);
        ack = 1'b0;
        ret = 1'b0;
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1");
        set_in(10'b10_0000_0000, '0);
        check("R1");

        // R2 R3: every vector alone with every level code
        for (int v = 0; v < NV; v++) begin
            for (int c = 0; c < 4; c++) begin
                set_in(NV'(1) << v, (2*NV)'(c) << (2*v));
                check("R2");
            end
        end

        // R4 R5: mixed patterns with an empty stack
        for (int i = 0; i < 300; i++) begin
            step_lfsr();
            set_in(lfsr[NV-1:0], {lfsr[3:0], lfsr});
            check("R4");
            check("R5");
        end

        // R6 R7 R11: nesting low -> high -> highest
        set_in(10'b00_0010_0000, 20'h00002);
        check("R6");
        strobe(1, 0);
        check("R7");
        set_in(10'b00_0010_0100, 20'h00012);
        check("R6");
        strobe(1, 0);
        check("R7");
        set_in(10'b00_0010_0101, 20'h00016);
        check("R11");
        strobe(1, 0);
        check("R11");
        set_in(10'b00_0010_0111, 20'h00016);
        check("R6");
        strobe(0, 1);
        check("R8");
        strobe(0, 1);
        check("R8");
        strobe(0, 1);
        check("R8");
        strobe(0, 1);
        check("R8");

        // R9: acknowledge with nothing offered
        set_in('0, 20'h00016);
        strobe(1, 0);
        check("R9");
        set_in(10'b00_0010_0000, 20'h00016);
        check("R9");

        // R10: acknowledge and return together
        strobe(1, 0);
        check("R10");
        set_in(10'b00_0010_0100, 20'h00010);
        check("R10");
        strobe(1, 1);
        check("R10");
        strobe(0, 1);
        check("R10");
        strobe(0, 1);
        check("R10");

        // mixed strobes over changing patterns
        for (int i = 0; i < 400; i++) begin
            step_lfsr();
            set_in(lfsr[NV-1:0], {lfsr[7:4], lfsr});
            check("R6");
            strobe(lfsr[2], lfsr[9] & lfsr[5]);
            check("R10");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule